// File: doc/BRIEF.md
# Serial Character Receiver with Break Detection

This block receives asynchronous serial characters and queues them for software. An external tick at sixteen times the bit rate drives the sampling. The frame is one start bit, eight data bits sent least significant bit first, and one stop bit. Each bit is sampled at its centre. Every character enters a sixteen-entry queue. Each queue entry stores the byte together with a one-bit tag, and the tag is set when the stop bit was sampled low.

The block also watches for a break. A break is a character with a bad stop bit, followed by a line that stays low for at least one whole frame time. When this happens a sticky flag is raised and driven out as an interrupt. No further characters are queued until the line goes high again. Software sees two registers. Register 0 returns the byte at the queue head, and reading it removes that entry. Register 1 is status: bit 4 is the sticky break flag and bit 3 is the error tag of the head entry. The break flag can only be cleared in two steps: read it as 1, then write 0 to bit 4.

The receive sequencer has six states:
- IDLE waits for a low sample and moves to START.
- START counts half a bit. It moves to DATA if the line is still low, or falls back to IDLE if the line has gone high (a glitch).
- DATA takes eight samples, one bit period apart, then moves to STOP.
- STOP samples the stop bit and queues the character. A high stop bit returns to IDLE. A low stop bit moves to WATCH.
- WATCH returns to IDLE as soon as the line goes high. If the line stays low for a full frame time it moves to BREAK and raises the flag.
- BREAK returns to IDLE once the line is high.

Top module: `uart_rx_brk`

## Requirements
- R1: A frame with a high stop bit is queued with its eight data bits, received least significant bit first, and an error tag of 0.
- R2: A frame whose stop-bit sample is low is still queued, with an error tag of 1.
- R3: After a frame with a low stop bit, if the line stays low for one full frame time (160 ticks), status bit 4 and `break_irq` go to 1.
- R4: While a break is active, nothing is added to the queue. When the line returns high, reception resumes and later frames are queued normally.
- R5: Writing 0 to status bit 4 clears the break flag only if the flag has been read as 1 since it was last cleared. A write of 0 without that read, or a write of 1, leaves the flag unchanged.
- R6: Status bit 3 equals the error tag of the head entry, and reads 0 when the queue is empty. Writes to status bit 3 have no effect. All other status bits read 0.
- R7: Reading register 0 returns the head byte (0 when the queue is empty) and removes the head entry. Status bit 3 shows the new head's tag from the next cycle.
- R8: The queue holds 16 entries. When it is full, `fifo_full` is 1 and any further frames are dropped. `fifo_count` reports the number of entries.
- R9: After reset the queue is empty, the count is 0, both flags are 0, and `break_irq` is 0.
- R10: A low pulse that has ended before the middle of the start bit is ignored, and nothing is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rxd | input | 1 | Serial line, high when idle |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 data, 1 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_count | output | 5 | Number of queued entries |
| break_irq | output | 1 | Break flag level |

## Verification
The assertions check the following on every cycle:
- the break flag only falls in the cycle after a status write;
- a break is only declared while the synchronised line is low;
- the queue count never exceeds its depth;
- a push into a full queue leaves the count unchanged;
- a pop with no push lowers the count by one.

Some behaviour can only be shown by the bench's scenarios:
- correct byte assembly across a sweep of data values;
- error tags following the head as entries are popped;
- suppression of characters while the line is held low;
- rejection of a glitch;
- the read-then-write rule for clearing the flag.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_STOP,
        S_WATCH,
        S_BREAK
    } rx_state_t;

    localparam int STAT_BRK_BIT = 4;
    localparam int STAT_FER_BIT = 3;
endpackage

// File: rtl/uart_rx_core.sv
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          tick,
    output logic          push,
    output logic [DW:0]   push_data,
    output logic          brk_set
);
    localparam int FRAME_TICKS = OVS * (DW + 2);
    localparam int CW          = $clog2(FRAME_TICKS);
    localparam int BW          = $clog2(DW);

    rx_state_t         state, state_n;
    logic [CW-1:0]     cnt, cnt_n;
    logic [BW-1:0]     bit_idx, bit_n;
    logic [DW-1:0]     sh, sh_n;
    logic              rxd_q1, rxd_s;
    logic              push_err;

    // two-stage synchroniser on the serial line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_q1 <= 1'b1;
            rxd_s  <= 1'b1;
        end else begin
            rxd_q1 <= rxd;
            rxd_s  <= rxd_q1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            sh      <= '0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            bit_idx <= bit_n;
            sh      <= sh_n;
        end
    end

    // transitions and outputs
    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        bit_n    = bit_idx;
        sh_n     = sh;
        push     = 1'b0;
        push_err = 1'b0;
        brk_set  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (tick && !rxd_s) begin
                    state_n = S_START;
                    cnt_n   = '0;
                end
            end
            S_START: begin
                if (tick) begin
                    if (cnt == CW'(OVS/2 - 1)) begin
                        cnt_n = '0;
                        bit_n = '0;
                        state_n = rxd_s ? S_IDLE : S_DATA;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_DATA: begin
                if (tick) begin
                    if (cnt == CW'(OVS - 1)) begin
                        cnt_n = '0;
                        sh_n  = {rxd_s, sh[DW-1:1]};
                        if (bit_idx == BW'(DW - 1)) state_n = S_STOP;
                        else                        bit_n   = bit_idx + 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_STOP: begin
                if (tick) begin
                    if (cnt == CW'(OVS - 1)) begin
                        cnt_n = '0;
                        push  = 1'b1;
                        if (rxd_s) begin
                            state_n = S_IDLE;
                        end else begin
                            push_err = 1'b1;
                            state_n  = S_WATCH;
                        end
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_WATCH: begin
                if (rxd_s) begin
                    state_n = S_IDLE;
                end else if (tick) begin
                    if (cnt == CW'(FRAME_TICKS - 1)) begin
                        brk_set = 1'b1;
                        state_n = S_BREAK;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            S_BREAK: begin
                if (rxd_s) state_n = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    assign push_data = {push_err, sh};

    // R3
    brk_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_set |-> !rxd_s);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 9
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R8
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (count == $past(count)));
    // R7
    pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/uart_rx_brk.sv
module uart_rx_brk
    import uart_rx_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rxd,
    input  logic                       baud_tick,
    input  logic                       rd_en,
    input  logic                       wr_en,
    input  logic                       addr,
    input  logic [7:0]                 wdata,
    output logic [7:0]                 rdata,
    output logic                       fifo_empty,
    output logic                       fifo_full,
    output logic [$clog2(DEPTH+1)-1:0] fifo_count,
    output logic                       break_irq
);
    logic          push, brk_set, pop;
    logic [DW:0]   push_data, head;
    logic          brk_flag, brk_seen;
    logic          fer;
    logic          brk_clear;

    uart_rx_core #(.OVS(OVS), .DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(baud_tick),
        .push(push), .push_data(push_data), .brk_set(brk_set)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .WIDTH(DW + 1)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_data),
        .pop(pop), .head(head), .empty(fifo_empty), .full(fifo_full),
        .count(fifo_count)
    );

    assign pop       = rd_en && !addr && !fifo_empty;
    assign fer       = !fifo_empty && head[DW];
    assign brk_clear = wr_en && addr && !wdata[STAT_BRK_BIT] && brk_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_flag <= 1'b0;
            brk_seen <= 1'b0;
        end else begin
            if (brk_set) begin
                brk_flag <= 1'b1;
            end else if (brk_clear) begin
                brk_flag <= 1'b0;
                brk_seen <= 1'b0;
            end
            if (rd_en && addr && brk_flag && !brk_clear) brk_seen <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr) begin
            rdata[STAT_BRK_BIT] = brk_flag;
            rdata[STAT_FER_BIT] = fer;
        end else if (!fifo_empty) begin
            rdata = 8'(head[DW-1:0]);
        end
    end

    assign break_irq = brk_flag;

    // R5
    brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(brk_flag) |-> $past(wr_en && addr && !wdata[STAT_BRK_BIT]));
endmodule

// File: tb/uart_rx_brk_tb.sv
module uart_rx_brk_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BIT_CLK    = 32;

    logic       clk = 0, rst_n = 0, rxd = 1, baud_tick = 0;
    logic       rd_en = 0, wr_en = 0, addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic       fifo_empty, fifo_full, break_irq;
    logic [4:0] fifo_count;
    int         n_chk = 0, n_bad = 0;

    uart_rx_brk u_dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .fifo_count(fifo_count), .break_irq(break_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int clks);
        rxd = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic stop);
        hold(1'b0, BIT_CLK);
        for (int i = 0; i < 8; i++) hold(d[i], BIT_CLK);
        hold(stop, BIT_CLK);
        rxd = 1'b1;
        if (stop) repeat (8) @(negedge clk);
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        addr = 1'b1; wdata = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R9 reset state
        check("R9 empty", fifo_empty, 1);
        check("R9 count", fifo_count, 0);
        check("R9 irq", break_irq, 0);
        rd(1'b1, v);
        check("R9 status", v, 0);

        // R1 sweep of byte values, each read back
        for (int b = 0; b < 256; b += 3) begin
            send(8'(b), 1'b1);
            check("R1 count", fifo_count, 1);
            rd(1'b1, v);
            check("R6 fer clean", v, 0);
            rd(1'b0, v);
            check("R1 data", v, b);
            check("R7 popped", fifo_empty, 1);
        end

        // R10 short glitch ignored
        hold(1'b0, 4);
        hold(1'b1, 12 * BIT_CLK);
        check("R10 glitch", fifo_count, 0);

        // R2 framing error tag, then clean frame; R7 tag follows head
        send(8'hA5, 1'b0);
        hold(1'b1, 16);
        send(8'h5A, 1'b1);
        check("R2 count", fifo_count, 2);
        rd(1'b1, v);
        check("R2 fer head", v, 8'h08);
        wr(8'h00);
        rd(1'b1, v);
        check("R6 fer read-only", v, 8'h08);
        rd(1'b0, v);
        check("R2 data", v, 8'hA5);
        rd(1'b1, v);
        check("R7 fer new head", v, 8'h00);
        rd(1'b0, v);
        check("R1 data 2", v, 8'h5A);
        wr(8'h08);
        rd(1'b1, v);
        check("R6 empty fer", v, 8'h00);
        rd(1'b0, v);
        check("R7 empty read", v, 8'h00);

        // R8 fill beyond depth
        for (int k = 0; k < 18; k++) send(8'(k * 7 + 1), 1'b1);
        check("R8 count", fifo_count, 16);
        check("R8 full", fifo_full, 1);
        for (int k = 0; k < 16; k++) begin
            rd(1'b0, v);
            check("R8 order", v, 8'(k * 7 + 1));
        end
        check("R8 drained", fifo_empty, 1);

        // R3 break detection and R4 suppression
        send(8'h00, 1'b0);
        hold(1'b0, 600);
        check("R3 irq", break_irq, 1);
        check("R4 suppressed", fifo_count, 1);
        hold(1'b1, 40);
        send(8'h3C, 1'b1);
        check("R4 resumed", fifo_count, 2);
        rd(1'b0, v);
        check("R4 first byte", v, 8'h00);
        rd(1'b0, v);
        check("R4 resumed byte", v, 8'h3C);

        // R5 clear rules
        wr(8'h00);
        check("R5 no prior read", break_irq, 1);
        rd(1'b1, v);
        check("R3 status bit4", v, 8'h10);
        wr(8'h10);
        check("R5 write one", break_irq, 1);
        wr(8'h00);
        check("R5 cleared", break_irq, 0);
        rd(1'b1, v);
        check("R5 status", v, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule